// File: doc/BRIEF.md
# Privilege-Level Memory Access Firewall

This block sits between a microcontroller's data bus and its on-chip RAM and decides, in the same cycle as each bus request, whether the request may reach memory. RAM is carved into seven address regions: a code part and a data part for each of three privilege levels (0 is the most trusted, 2 the least), and one public data area that every level shares. Code may work on its own level's data and on public data. It may load code into a less trusted level's code region. It may never touch the data of a more trusted level.

A small parameter window at the bottom of the level-0 area holds the chip's authority and state bytes and is guarded more tightly than the rest of the map. The top of that window is reserved and can never be written. A refused write never reaches memory and a refused read returns zero. The first refusal after reset is latched together with its address, level and direction, and the record stays until the next reset. The region bounds are parameters. The decode has no registers, so the grant is valid in the same cycle as the address.

Top module: `priv_mem_firewall`

## Requirements
- R1: `acc_grant`, `mem_we` and `mem_re` are combinational functions of the current request. With `acc_valid` low all three are 0 and nothing is logged.
- R2: The default map assigns these regions. Level-0 data is 0000h–0FFFh and level-0 code is 1000h–3FFFh. Level-1 code is 4000h–5FFFh and level-1 data is 6000h–6FFFh. Level-2 code is 7000h–9FFFh and level-2 data is A000h–BFFFh. Public is C000h–FFFFh. `acc_level` encodes levels 0, 1 and 2 as 0, 1 and 2; the value 3 is invalid and every request carrying it is refused.
- R3: A fetch (`acc_is_code`=1) is granted only from the code region of the requester's own level.
- R4: A data access (`acc_is_code`=0) to a data region is granted only when the region's level equals the requester's level.
- R5: A data read or write to a code region is granted when the region's level number is strictly greater than the requester's level, and refused otherwise.
- R6: The public area grants data reads and writes to every valid level and refuses fetches.
- R7: Inside the parameter window 0000h–03FFh, only level-0 data accesses are granted. Writes to the reserved range 03A0h–03FFh are refused at every level, and level-0 reads there are granted.
- R8: `mem_we` is 1 only for a granted write and `mem_re` only for a granted read. `rd_data` equals `mem_rdata` for a granted read and is 0 otherwise.
- R9: A refused valid request sets `viol_flag` at the next clock edge. If the flag was clear, the same edge captures the address, level and write bit into `viol_addr`, `viol_level` and `viol_write`.
- R10: While `viol_flag` is set, later refusals leave the captured record unchanged, and the flag stays set until reset.
- R11: Reset (`rst_n` low) clears `viol_flag`, `viol_addr`, `viol_level` and `viol_write` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | A bus request is present |
| acc_level | input | 2 | Privilege level of the running code (3 is invalid) |
| acc_addr | input | AW | Byte address of the request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_is_code | input | 1 | 1 = instruction fetch, 0 = data access |
| mem_rdata | input | DW | Read data returned by the memory |
| acc_grant | output | 1 | Request is permitted this cycle |
| mem_we | output | 1 | Write enable toward the memory |
| mem_re | output | 1 | Read enable toward the memory |
| rd_data | output | DW | Read data returned to the processor, zero when refused |
| viol_flag | output | 1 | Sticky refusal indicator |
| viol_addr | output | AW | Address of the first refused request |
| viol_level | output | 2 | Level of the first refused request |
| viol_write | output | 1 | Direction of the first refused request |

## Verification
The assertions assume that `acc_level`, `acc_addr`, `acc_write` and `acc_is_code` carry known values whenever `acc_valid` is high. They also assume that the inputs settle before the rising edge, so that the refusal seen during the cycle is the one the log samples. The bench changes inputs only on falling edges and holds them through the next rising edge. It deliberately includes the invalid level value 3, addresses folded into the parameter window, and requests with `acc_valid` low, so that every branch of the policy runs while those assumptions still hold.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int NUM_REGIONS = 7;

    // Region index order is the decode priority (lowest index wins on overlap).
    typedef enum logic [2:0] {
        REG_L0_CODE = 3'd0,
        REG_L0_DATA = 3'd1,
        REG_L1_CODE = 3'd2,
        REG_L1_DATA = 3'd3,
        REG_L2_CODE = 3'd4,
        REG_L2_DATA = 3'd5,
        REG_PUBLIC  = 3'd6,
        REG_NONE    = 3'd7
    } fw_region_e;

    typedef enum logic [1:0] {
        KIND_CODE   = 2'd0,
        KIND_DATA   = 2'd1,
        KIND_PUBLIC = 2'd2,
        KIND_NONE   = 2'd3
    } fw_kind_e;

    typedef struct packed {
        fw_kind_e   kind;
        logic [1:0] owner;
        logic       in_param;
        logic       in_rsvd;
    } fw_decode_t;

    function automatic fw_kind_e region_kind(input fw_region_e r);
        fw_kind_e k;
        unique case (r)
            REG_L0_CODE, REG_L1_CODE, REG_L2_CODE: k = KIND_CODE;
            REG_L0_DATA, REG_L1_DATA, REG_L2_DATA: k = KIND_DATA;
            REG_PUBLIC:                            k = KIND_PUBLIC;
            default:                               k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [1:0] region_owner(input fw_region_e r);
        logic [1:0] o;
        unique case (r)
            REG_L1_CODE, REG_L1_DATA: o = 2'd1;
            REG_L2_CODE, REG_L2_DATA: o = 2'd2;
            default:                  o = 2'd0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/fw_region_decode.sv
module fw_region_decode
    import fw_pkg::*;
#(
    parameter int             AW = 16,
    parameter logic [AW-1:0]  BASE_TAB  [NUM_REGIONS] = '{default: '0},
    parameter logic [AW-1:0]  LIMIT_TAB [NUM_REGIONS] = '{default: '0},
    parameter logic [AW-1:0]  PARAM_BASE  = '0,
    parameter logic [AW-1:0]  PARAM_LIMIT = '0,
    parameter logic [AW-1:0]  RSVD_BASE   = '0,
    parameter logic [AW-1:0]  RSVD_LIMIT  = '0
) (
    input  logic [AW-1:0] addr,
    output fw_decode_t    dec
);

    localparam int IDXW = $clog2(NUM_REGIONS + 1);

    logic [NUM_REGIONS-1:0] hit;
    fw_region_e             sel;

    // One comparator pair per region.
    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
            assign hit[g] = (addr >= BASE_TAB[g]) && (addr <= LIMIT_TAB[g]);
        end
    endgenerate

    // Priority select: lowest region index wins.
    always_comb begin
        logic [IDXW-1:0] idx;
        idx = IDXW'(REG_NONE);
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = IDXW'(i);
            end
        end
        sel = fw_region_e'(idx);
    end

    always_comb begin
        dec          = '0;
        dec.kind     = region_kind(sel);
        dec.owner    = region_owner(sel);
        dec.in_param = (addr >= PARAM_BASE) && (addr <= PARAM_LIMIT);
        dec.in_rsvd  = (addr >= RSVD_BASE) && (addr <= RSVD_LIMIT);
    end

endmodule

// File: rtl/fw_access_policy.sv
module fw_access_policy
    import fw_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] level,
    input  logic       write,
    input  logic       is_code,
    input  fw_decode_t dec,
    output logic       grant
);

    localparam logic [1:0] LVL_INVALID = 2'd3;
    localparam logic [1:0] LVL_ROOT    = 2'd0;

    logic region_ok;
    logic window_ok;

    // Region-class rules.
    always_comb begin
        region_ok = 1'b0;
        unique case (dec.kind)
            KIND_CODE: begin
                if (is_code) region_ok = (dec.owner == level);
                else         region_ok = (dec.owner > level);
            end
            KIND_DATA:   region_ok = !is_code && (dec.owner == level);
            KIND_PUBLIC: region_ok = !is_code;
            default:     region_ok = 1'b0;
        endcase
    end

    // Extra guard for the parameter window and its reserved tail.
    always_comb begin
        window_ok = 1'b1;
        if (dec.in_param && (level != LVL_ROOT || is_code)) window_ok = 1'b0;
        if (dec.in_rsvd && write)                            window_ok = 1'b0;
    end

    assign grant = valid && (level != LVL_INVALID) && region_ok && window_ok;

endmodule

// File: rtl/fw_violation_log.sv
module fw_violation_log #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deny_evt,
    input  logic [AW-1:0] deny_addr,
    input  logic [1:0]    deny_level,
    input  logic          deny_write,
    output logic          flag,
    output logic [AW-1:0] addr,
    output logic [1:0]    level,
    output logic          write
);

    typedef struct packed {
        logic          flag;
        logic [AW-1:0] addr;
        logic [1:0]    level;
        logic          write;
    } log_state_t;

    log_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (deny_evt && !st_q.flag) begin
            st_d.flag  = 1'b1;
            st_d.addr  = deny_addr;
            st_d.level = deny_level;
            st_d.write = deny_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag  = st_q.flag;
    assign addr  = st_q.addr;
    assign level = st_q.level;
    assign write = st_q.write;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R10
    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> ($stable(addr) && $stable(level) && $stable(write))); // R10
    AST_DENY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        deny_evt |=> flag); // R9
    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_evt && !flag) |=> (addr == $past(deny_addr))); // R9

endmodule

// File: rtl/priv_mem_firewall.sv
module priv_mem_firewall
    import fw_pkg::*;
#(
    parameter int            AW = 16,
    parameter int            DW = 8,
    parameter logic [AW-1:0] L0_CODE_BASE  = 16'h1000,
    parameter logic [AW-1:0] L0_CODE_LIMIT = 16'h3FFF,
    parameter logic [AW-1:0] L0_DATA_BASE  = 16'h0000,
    parameter logic [AW-1:0] L0_DATA_LIMIT = 16'h0FFF,
    parameter logic [AW-1:0] L1_CODE_BASE  = 16'h4000,
    parameter logic [AW-1:0] L1_CODE_LIMIT = 16'h5FFF,
    parameter logic [AW-1:0] L1_DATA_BASE  = 16'h6000,
    parameter logic [AW-1:0] L1_DATA_LIMIT = 16'h6FFF,
    parameter logic [AW-1:0] L2_CODE_BASE  = 16'h7000,
    parameter logic [AW-1:0] L2_CODE_LIMIT = 16'h9FFF,
    parameter logic [AW-1:0] L2_DATA_BASE  = 16'hA000,
    parameter logic [AW-1:0] L2_DATA_LIMIT = 16'hBFFF,
    parameter logic [AW-1:0] PUB_BASE      = 16'hC000,
    parameter logic [AW-1:0] PUB_LIMIT     = 16'hFFFF,
    parameter logic [AW-1:0] PARAM_BASE    = 16'h0000,
    parameter logic [AW-1:0] PARAM_LIMIT   = 16'h03FF,
    parameter logic [AW-1:0] RSVD_BASE     = 16'h03A0,
    parameter logic [AW-1:0] RSVD_LIMIT    = 16'h03FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [1:0]    acc_level,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          acc_is_code,
    input  logic [DW-1:0] mem_rdata,
    output logic          acc_grant,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] rd_data,
    output logic          viol_flag,
    output logic [AW-1:0] viol_addr,
    output logic [1:0]    viol_level,
    output logic          viol_write
);

    // Table order follows fw_region_e.
    localparam logic [AW-1:0] BASE_TAB [NUM_REGIONS] = '{
        L0_CODE_BASE, L0_DATA_BASE, L1_CODE_BASE, L1_DATA_BASE,
        L2_CODE_BASE, L2_DATA_BASE, PUB_BASE};
    localparam logic [AW-1:0] LIMIT_TAB [NUM_REGIONS] = '{
        L0_CODE_LIMIT, L0_DATA_LIMIT, L1_CODE_LIMIT, L1_DATA_LIMIT,
        L2_CODE_LIMIT, L2_DATA_LIMIT, PUB_LIMIT};

    fw_decode_t dec;
    logic       deny_evt;

    fw_region_decode #(
        .AW          (AW),
        .BASE_TAB    (BASE_TAB),
        .LIMIT_TAB   (LIMIT_TAB),
        .PARAM_BASE  (PARAM_BASE),
        .PARAM_LIMIT (PARAM_LIMIT),
        .RSVD_BASE   (RSVD_BASE),
        .RSVD_LIMIT  (RSVD_LIMIT)
    ) u_decode (
        .addr (acc_addr),
        .dec  (dec)
    );

    fw_access_policy u_policy (
        .valid   (acc_valid),
        .level   (acc_level),
        .write   (acc_write),
        .is_code (acc_is_code),
        .dec     (dec),
        .grant   (acc_grant)
    );

    assign deny_evt = acc_valid && !acc_grant;

    // Gate the memory side with the decision.
    always_comb begin
        mem_we  = acc_grant && acc_write;
        mem_re  = acc_grant && !acc_write;
        rd_data = mem_re ? mem_rdata : '0;
    end

    fw_violation_log #(
        .AW (AW)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .deny_evt   (deny_evt),
        .deny_addr  (acc_addr),
        .deny_level (acc_level),
        .deny_write (acc_write),
        .flag       (viol_flag),
        .addr       (viol_addr),
        .level      (viol_level),
        .write      (viol_write)
    );

    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(mem_we || mem_re)); // R1
    AST_INVALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_level == 2'd3) |-> !mem_we && !mem_re); // R2
    AST_FETCH_OWN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_code && acc_grant) |-> (dec.kind == KIND_CODE && dec.owner == acc_level)); // R3
    AST_DATA_OWN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && dec.kind == KIND_DATA) |-> (dec.owner == acc_level)); // R4
    AST_LOAD_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && !acc_is_code && dec.kind == KIND_CODE) |-> (dec.owner > acc_level)); // R5
    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.in_rsvd && acc_write) |-> !mem_we); // R7
    AST_WINDOW_ROOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && dec.in_param) |-> (acc_level == 2'd0)); // R7
    AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_grant) |-> (rd_data == '0)); // R8

endmodule

// File: tb/priv_mem_firewall_bench.sv
module priv_mem_firewall_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [1:0]  acc_level;
    logic [15:0] acc_addr;
    logic        acc_write;
    logic        acc_is_code;
    logic [7:0]  mem_rdata;
    logic        acc_grant, mem_we, mem_re;
    logic [7:0]  rd_data;
    logic        viol_flag;
    logic [15:0] viol_addr;
    logic [1:0]  viol_level;
    logic        viol_write;

    always #2 clk = ~clk;   // 250 MHz

    priv_mem_firewall u_priv_mem_firewall (
        .clk, .rst_n, .acc_valid, .acc_level, .acc_addr, .acc_write,
        .acc_is_code, .mem_rdata, .acc_grant, .mem_we, .mem_re, .rd_data,
        .viol_flag, .viol_addr, .viol_level, .viol_write
    );

    int n_chk = 0;
    int n_bad = 0;

    bit          m_flag;
    logic [15:0] m_addr;
    logic [1:0]  m_lvl;
    bit          m_wr;

    // Expected decision from the requirements R2-R7 with the default map.
    function automatic bit exp_grant(input logic [1:0] l, input logic [15:0] a,
                                     input bit w, input bit c);
        int kind;   // 0 code, 1 data, 2 public
        int own;
        if (l == 2'd3) return 1'b0;                       // R2
        if (a >= 16'h03A0 && a <= 16'h03FF && w) return 1'b0; // R7
        if (a <= 16'h03FF && (l != 2'd0 || c)) return 1'b0;   // R7
        if      (a <= 16'h0FFF) begin kind = 1; own = 0; end
        else if (a <= 16'h3FFF) begin kind = 0; own = 0; end
        else if (a <= 16'h5FFF) begin kind = 0; own = 1; end
        else if (a <= 16'h6FFF) begin kind = 1; own = 1; end
        else if (a <= 16'h9FFF) begin kind = 0; own = 2; end
        else if (a <= 16'hBFFF) begin kind = 1; own = 2; end
        else                    begin kind = 2; own = 0; end
        if (kind == 2) return !c;                          // R6
        if (kind == 1) return !c && (own == int'(l));      // R4
        if (c) return own == int'(l);                      // R3
        return own > int'(l);                              // R5
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit v, input logic [1:0] l, input logic [15:0] a,
                          input bit w, input bit c, input logic [7:0] rd,
                          input string req);
        bit eg;
        string vreq;
        @(negedge clk);
        acc_valid = v; acc_level = l; acc_addr = a; acc_write = w;
        acc_is_code = c; mem_rdata = rd;
        #1;
        eg = v && exp_grant(l, a, w, c);
        chk(req, "grant", 32'(acc_grant), 32'(eg));
        chk("R8", "mem_we", 32'(mem_we), 32'(eg && w));
        chk("R8", "mem_re", 32'(mem_re), 32'(eg && !w));
        chk("R8", "rd_data", 32'(rd_data), (eg && !w) ? 32'(rd) : 32'h0);
        vreq = m_flag ? "R10" : "R9";
        @(posedge clk);
        if (v && !eg && !m_flag) begin
            m_flag = 1'b1; m_addr = a; m_lvl = l; m_wr = w;
        end
        #1;
        chk(vreq, "viol_flag", 32'(viol_flag), 32'(m_flag));
        chk(vreq, "viol_addr", 32'(viol_addr), 32'(m_addr));
        chk(vreq, "viol_level", 32'(viol_level), 32'(m_lvl));
        chk(vreq, "viol_write", 32'(viol_write), 32'(m_wr));
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        m_flag = 1'b0; m_addr = '0; m_lvl = '0; m_wr = 1'b0;
        chk("R11", "viol_flag", 32'(viol_flag), 32'h0);
        chk("R11", "viol_addr", 32'(viol_addr), 32'h0);
        chk("R11", "viol_level", 32'(viol_level), 32'h0);
        chk("R11", "viol_write", 32'(viol_write), 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; acc_valid = 1'b0; acc_level = '0; acc_addr = '0;
        acc_write = 1'b0; acc_is_code = 1'b0; mem_rdata = '0;
        m_flag = 1'b0; m_addr = '0; m_lvl = '0; m_wr = 1'b0;
        do_reset();

        // Directed corner cases
        access(1'b0, 2'd3, 16'h03A5, 1'b1, 1'b0, 8'h11, "R1");  // idle: nothing logged
        access(1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 8'hA5, "R7");  // root reads flag byte
        access(1'b1, 2'd0, 16'h0001, 1'b1, 1'b0, 8'h00, "R7");  // root writes state byte
        access(1'b1, 2'd0, 16'h03FF, 1'b0, 1'b0, 8'h5A, "R7");  // root reads reserved
        access(1'b1, 2'd1, 16'hC000, 1'b1, 1'b0, 8'h00, "R6");
        access(1'b1, 2'd2, 16'hFFFF, 1'b0, 1'b0, 8'h3C, "R6");
        access(1'b1, 2'd1, 16'h4000, 1'b0, 1'b1, 8'h77, "R3");
        access(1'b1, 2'd0, 16'h7000, 1'b1, 1'b0, 8'h00, "R5");  // loader writes L2 code
        access(1'b1, 2'd2, 16'hA000, 1'b1, 1'b0, 8'h00, "R4");
        access(1'b1, 2'd0, 16'h03A0, 1'b1, 1'b0, 8'h00, "R7");  // first refusal
        access(1'b1, 2'd1, 16'h0001, 1'b0, 1'b0, 8'hFF, "R4");  // later refusal
        access(1'b1, 2'd2, 16'h4000, 1'b1, 1'b0, 8'h00, "R5");
        access(1'b1, 2'd0, 16'hC000, 1'b0, 1'b1, 8'h12, "R6");  // fetch public
        access(1'b1, 2'd3, 16'hC000, 1'b0, 1'b0, 8'h12, "R2");
        access(1'b1, 2'd1, 16'h6FFF, 1'b0, 1'b0, 8'h99, "R4");
        access(1'b1, 2'd1, 16'h1000, 1'b0, 1'b1, 8'h99, "R3");

        do_reset();
        access(1'b1, 2'd2, 16'h6000, 1'b0, 1'b0, 8'hEE, "R4");  // new first refusal
        access(1'b1, 2'd3, 16'h9000, 1'b1, 1'b1, 8'h00, "R2");

        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [1:0]  l;
            a = 16'($urandom);
            if ($urandom % 4 == 0) a = a & 16'h03FF;
            l = 2'($urandom % 4);
            access(($urandom % 8) != 0, l, a, 1'($urandom), ($urandom % 3) == 0,
                   8'($urandom), "R2");
            if (i == 1500) do_reset();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule